// File: doc/BRIEF.md
# I2C Buffered Burst Transfer Sequencer

This block runs the command level of an I2C master. A host programs it through a small register window, and the block drives a byte-level bit engine that owns the SCL/SDA timing. In packet-buffer mode a single command moves a whole run of bytes through a shared word-addressed buffer RAM. The bursts can go out to a device, come in from a device, or do both. When neither buffer-enable bit is set, each command moves exactly one byte through a byte data register.

The host loads the buffer RAM with whole 32-bit words. It sets the start offset, the transmit count and the receive size in the buffer control register, then writes a command. The sequencer then asks the bit engine for each step in turn: start, the transmit bytes, the receive bytes, then stop. After the last step it raises a done flag. The received-byte count is reported back in the buffer control register. A NACK from the device ends a transmit burst early.

Host word addresses: 0 command, 1 buffer control, 2 byte data, 3 interrupt flags. Word addresses 32 to 47 are the buffer RAM, which holds 64 bytes by default. The buffer byte for sequence index i is at byte address (offset + i) modulo the buffer size.

Top module: `i2c_burst_seq`

## Requirements
- R1: The buffer control register (word 1) reads back as received-byte count in bits 31:24, receive size in bits 23:16, transmit count in bits 15:8 and start offset in bits 5:0. Bits 7:6 read 0. Host writes to the count in bits 31:24 are ignored.
- R2: A host write to buffer word w stores bits 8i+7:8i as buffer byte 4w+i, for i = 0..3. A read of the word returns the same layout.
- R3: The transmit count and the receive size both encode the number of bytes minus one. A value of 0 moves exactly one byte.
- R4: Buffered transmit is command bit 6 together with bit 1. It sends buffer bytes offset+0 .. offset+count in index order. When start (bit 0) is also set, index 0 is the address byte and goes out first, right after the start step.
- R5: Buffered receive is command bit 7 together with bit 3. It stores the incoming bytes at offset+0 onward. When the burst ends, bits 31:24 of the buffer control register hold the number of bytes stored.
- R6: On a receive, the engine is told to NACK only the final byte of the burst, and only when last (bit 4) is set. Without bit 4, every byte is ACKed.
- R7: With the matching buffer-enable bit clear, a transmit sends one byte taken from byte data bits 7:0. A receive takes one byte into byte data bits 15:8 and leaves the buffer RAM and the count field unchanged.
- R8: A device NACK during a transmit ends the remaining transmit bytes and skips any receive. It sets the NACK flag (interrupt bit 1). In buffer mode the transmit count field is set to the index of the NACKed byte. Stop is still issued if the command asked for it.
- R9: The done flag (interrupt bit 0) stays low while a command is in progress. It rises once, when the whole command has finished. Writing 1 to a flag bit clears it.
- R10: The steps of one command run in the order start, transmit burst, receive burst, stop (bits 0, 1, 3, 5), skipping the steps that are not requested. Nothing is requested of the engine after stop.
- R11: A command written while the sequencer is busy is ignored.
- R12: A request to the engine holds its operation (0 start, 1 write byte, 2 read byte, 3 stop) and its write byte stable until the engine returns a one-cycle done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_we | input | 1 | Host write strobe |
| hst_addr | input | 6 | Host word address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data (combinational on hst_addr) |
| eng_req | output | 1 | Step request to the bit engine |
| eng_op | output | 2 | Requested step: 0 start, 1 write, 2 read, 3 stop |
| eng_wbyte | output | 8 | Byte to send on a write step |
| eng_rx_nack | output | 1 | On a read step: answer the byte with NACK |
| eng_done | input | 1 | One-cycle pulse: the requested step has finished |
| eng_rbyte | input | 8 | Byte received, valid with eng_done on a read step |
| eng_got_nack | input | 1 | Device NACKed the written byte, valid with eng_done |
| irq_done | output | 1 | Command-finished flag |
| irq_nack | output | 1 | Transmit NACK flag |

## Verification
The assertions assume that the bit engine pulses done for a single cycle and only while a request is pending. They also assume that the host leaves the buffer RAM alone while a transmit burst is reading it, since the write-byte stability check depends on that RAM content. The bench engine model answers each request after a fixed delay with a one-cycle pulse, and it drives the received byte and the NACK answer in the same cycle as that pulse. The host tasks load the buffer only between commands; the only write made during a busy period is the ignored command.

// File: rtl/i2c_burst_pkg.sv
`timescale 1ns/1ps
package i2c_burst_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_START = 3'd1,
    PH_TX    = 3'd2,
    PH_RX    = 3'd3,
    PH_STOP  = 3'd4
  } phase_e;

  localparam logic [1:0] OP_START = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_READ  = 2'd2;
  localparam logic [1:0] OP_STOP  = 2'd3;

  // command word, bit 7 down to bit 0
  typedef struct packed {
    logic rxbuf;
    logic txbuf;
    logic stop;
    logic last;
    logic rx;
    logic spare;
    logic tx;
    logic start;
  } cmd_t;

  localparam int REG_CMD    = 0;
  localparam int REG_BUFCTL = 1;
  localparam int REG_DATA   = 2;
  localparam int REG_INT    = 3;

endpackage

// File: rtl/i2c_burst_bufram.sv
`timescale 1ns/1ps
module i2c_burst_bufram #(
  parameter int BUF_WORDS = 16,
  localparam int BUF_BYTES = BUF_WORDS * 4,
  localparam int WIDX_W = $clog2(BUF_WORDS),
  localparam int BA_W = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              host_we,
  input  logic [WIDX_W-1:0] host_idx,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic              seq_we,
  input  logic [BA_W-1:0]   seq_addr,
  input  logic [7:0]        seq_wdata,
  output logic [7:0]        seq_rdata
);

  logic [7:0] cells [BUF_BYTES];

  for (genvar b = 0; b < BUF_BYTES; b++) begin : g_cell
    logic [7:0] cell_q;
    logic       host_hit;
    logic       seq_hit;
    logic [7:0] cell_d;

    assign host_hit = host_we && (host_idx == WIDX_W'(b / 4));
    assign seq_hit  = seq_we && (seq_addr == BA_W'(b));

    always_comb begin
      cell_d = cell_q;
      if (host_hit) cell_d = host_wdata[8*(b%4) +: 8];
      if (seq_hit)  cell_d = seq_wdata;
    end

    always_ff @(posedge clk) begin
      if (host_hit || seq_hit) cell_q <= cell_d;
    end

    assign cells[b] = cell_q;
  end

  assign host_rdata = {cells[4*host_idx+3], cells[4*host_idx+2],
                       cells[4*host_idx+1], cells[4*host_idx]};
  assign seq_rdata  = cells[seq_addr];

endmodule

// File: rtl/i2c_burst_ctl.sv
`timescale 1ns/1ps
module i2c_burst_ctl
  import i2c_burst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       go,
  input  cmd_t       go_cmd,
  input  logic [7:0] tx_last,
  input  logic [7:0] rx_last,
  input  logic       eng_done,
  input  logic       eng_got_nack,
  output phase_e     phase,
  output logic [7:0] idx,
  output cmd_t       cmd_q,
  output logic       eng_req,
  output logic [1:0] eng_op,
  output logic       eng_rx_nack,
  output logic       store,
  output logic       nack_evt,
  output logic       fin
);

  phase_e     ph_q, ph_d;
  logic [7:0] idx_q, idx_d;
  cmd_t       cmd_d;

  function automatic phase_e pick(input logic t, input logic r, input logic s);
    if (t)      return PH_TX;
    else if (r) return PH_RX;
    else if (s) return PH_STOP;
    else        return PH_IDLE;
  endfunction

  always_comb begin
    ph_d     = ph_q;
    idx_d    = idx_q;
    cmd_d    = cmd_q;
    store    = 1'b0;
    nack_evt = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (go) begin
          cmd_d = go_cmd;
          idx_d = 8'd0;
          ph_d  = go_cmd.start ? PH_START : pick(go_cmd.tx, go_cmd.rx, go_cmd.stop);
        end
      end
      PH_START: begin
        if (eng_done) ph_d = pick(cmd_q.tx, cmd_q.rx, cmd_q.stop);
      end
      PH_TX: begin
        if (eng_done) begin
          if (eng_got_nack) begin
            nack_evt = 1'b1;
            idx_d    = 8'd0;
            ph_d     = cmd_q.stop ? PH_STOP : PH_IDLE;
          end else if (idx_q == tx_last) begin
            idx_d = 8'd0;
            ph_d  = pick(1'b0, cmd_q.rx, cmd_q.stop);
          end else begin
            idx_d = idx_q + 8'd1;
          end
        end
      end
      PH_RX: begin
        if (eng_done) begin
          store = 1'b1;
          if (idx_q == rx_last) begin
            idx_d = 8'd0;
            ph_d  = pick(1'b0, 1'b0, cmd_q.stop);
          end else begin
            idx_d = idx_q + 8'd1;
          end
        end
      end
      PH_STOP: begin
        if (eng_done) ph_d = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  assign fin = ((ph_q != PH_IDLE) || go) && (ph_d == PH_IDLE);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      idx_q <= 8'd0;
      cmd_q <= '0;
    end else begin
      ph_q  <= ph_d;
      idx_q <= idx_d;
      cmd_q <= cmd_d;
    end
  end

  always_comb begin
    unique case (ph_q)
      PH_START: eng_op = OP_START;
      PH_TX:    eng_op = OP_WRITE;
      PH_RX:    eng_op = OP_READ;
      default:  eng_op = OP_STOP;
    endcase
  end

  assign eng_req     = (ph_q != PH_IDLE);
  assign eng_rx_nack = (ph_q == PH_RX) && cmd_q.last && (idx_q == rx_last);
  assign phase       = ph_q;
  assign idx         = idx_q;

endmodule

// File: rtl/i2c_burst_seq.sv
`timescale 1ns/1ps
module i2c_burst_seq
  import i2c_burst_pkg::*;
#(
  parameter int BUF_WORDS = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_we,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [31:0]       hst_wdata,
  output logic [31:0]       hst_rdata,
  output logic              eng_req,
  output logic [1:0]        eng_op,
  output logic [7:0]        eng_wbyte,
  output logic              eng_rx_nack,
  input  logic              eng_done,
  input  logic [7:0]        eng_rbyte,
  input  logic              eng_got_nack,
  output logic              irq_done,
  output logic              irq_nack
);

  localparam int BUF_BYTES = BUF_WORDS * 4;
  localparam int BA_W = $clog2(BUF_BYTES);
  localparam int WIDX_W = $clog2(BUF_WORDS);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  // host decode
  logic buf_sel, cmd_hit, ctl_hit, data_hit, int_hit, busy, go;
  assign buf_sel  = hst_addr[ADDR_W-1];
  assign cmd_hit  = hst_we && (hst_addr == ADDR_W'(REG_CMD));
  assign ctl_hit  = hst_we && (hst_addr == ADDR_W'(REG_BUFCTL));
  assign data_hit = hst_we && (hst_addr == ADDR_W'(REG_DATA));
  assign int_hit  = hst_we && (hst_addr == ADDR_W'(REG_INT));
  assign go       = cmd_hit && !busy;

  // sequencer
  phase_e     phase;
  logic [7:0] idx;
  cmd_t       cmd_q;
  logic       store, nack_evt, fin;
  logic [7:0] tx_cnt_q, rx_size_q, rx_cnt_q, tx_byte_q, rx_byte_q;
  logic [5:0] ofs_q;
  logic [7:0] tx_last, rx_last;

  assign tx_last = cmd_q.txbuf ? tx_cnt_q : 8'd0;
  assign rx_last = cmd_q.rxbuf ? rx_size_q : 8'd0;

  i2c_burst_ctl u_ctl (
    .clk          (clk),
    .rst_ni       (rst_ni),
    .go           (go),
    .go_cmd       (cmd_t'(hst_wdata[7:0])),
    .tx_last      (tx_last),
    .rx_last      (rx_last),
    .eng_done     (eng_done),
    .eng_got_nack (eng_got_nack),
    .phase        (phase),
    .idx          (idx),
    .cmd_q        (cmd_q),
    .eng_req      (eng_req),
    .eng_op       (eng_op),
    .eng_rx_nack  (eng_rx_nack),
    .store        (store),
    .nack_evt     (nack_evt),
    .fin          (fin)
  );

  assign busy = (phase != PH_IDLE);

  // buffer RAM
  logic [7:0]      addr_sum;
  logic [BA_W-1:0] seq_addr;
  logic [31:0]     ram_word;
  logic [7:0]      ram_byte;

  assign addr_sum = {2'b00, ofs_q} + idx;
  assign seq_addr = addr_sum[BA_W-1:0];

  i2c_burst_bufram #(.BUF_WORDS(BUF_WORDS)) u_ram (
    .clk        (clk),
    .host_we    (hst_we && buf_sel),
    .host_idx   (hst_addr[WIDX_W-1:0]),
    .host_wdata (hst_wdata),
    .host_rdata (ram_word),
    .seq_we     (store && cmd_q.rxbuf),
    .seq_addr   (seq_addr),
    .seq_wdata  (eng_rbyte),
    .seq_rdata  (ram_byte)
  );

  assign eng_wbyte = cmd_q.txbuf ? ram_byte : tx_byte_q;

  // register next state
  logic [7:0] tx_cnt_d, rx_size_d, rx_cnt_d, tx_byte_d, rx_byte_d;
  logic [5:0] ofs_d;
  logic       done_q, done_d, nack_q, nack_d;

  always_comb begin
    tx_cnt_d  = tx_cnt_q;
    rx_size_d = rx_size_q;
    rx_cnt_d  = rx_cnt_q;
    ofs_d     = ofs_q;
    tx_byte_d = tx_byte_q;
    rx_byte_d = rx_byte_q;
    done_d    = done_q;
    nack_d    = nack_q;

    if (ctl_hit && !busy) begin
      rx_size_d = hst_wdata[23:16];
      tx_cnt_d  = hst_wdata[15:8];
      ofs_d     = hst_wdata[5:0];
    end
    if (data_hit && !busy) tx_byte_d = hst_wdata[7:0];

    if (go && hst_wdata[7])            rx_cnt_d  = 8'd0;
    if (store && cmd_q.rxbuf)          rx_cnt_d  = idx + 8'd1;
    if (store && !cmd_q.rxbuf)         rx_byte_d = eng_rbyte;
    if (nack_evt && cmd_q.txbuf)       tx_cnt_d  = idx;

    if (int_hit && hst_wdata[0]) done_d = 1'b0;
    if (int_hit && hst_wdata[1]) nack_d = 1'b0;
    if (fin)                     done_d = 1'b1;
    if (nack_evt)                nack_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_cnt_q  <= 8'd0;
      rx_size_q <= 8'd0;
      rx_cnt_q  <= 8'd0;
      ofs_q     <= 6'd0;
      tx_byte_q <= 8'd0;
      rx_byte_q <= 8'd0;
      done_q    <= 1'b0;
      nack_q    <= 1'b0;
    end else begin
      tx_cnt_q  <= tx_cnt_d;
      rx_size_q <= rx_size_d;
      rx_cnt_q  <= rx_cnt_d;
      ofs_q     <= ofs_d;
      tx_byte_q <= tx_byte_d;
      rx_byte_q <= rx_byte_d;
      done_q    <= done_d;
      nack_q    <= nack_d;
    end
  end

  assign irq_done = done_q;
  assign irq_nack = nack_q;

  // host read mux
  always_comb begin
    hst_rdata = 32'd0;
    if (buf_sel) begin
      hst_rdata = ram_word;
    end else begin
      case (hst_addr)
        ADDR_W'(REG_CMD):    hst_rdata = {24'd0, cmd_q};
        ADDR_W'(REG_BUFCTL): hst_rdata = {rx_cnt_q, rx_size_q, tx_cnt_q, 2'b00, ofs_q};
        ADDR_W'(REG_DATA):   hst_rdata = {16'd0, rx_byte_q, tx_byte_q};
        ADDR_W'(REG_INT):    hst_rdata = {30'd0, nack_q, done_q};
        default:             hst_rdata = 32'd0;
      endcase
    end
  end

endmodule

// File: rtl/i2c_burst_seq_chk.sv
`timescale 1ns/1ps
module i2c_burst_seq_chk (
  input logic       clk,
  input logic       rst_ni,
  input logic       eng_req,
  input logic [1:0] eng_op,
  input logic [7:0] eng_wbyte,
  input logic       eng_rx_nack,
  input logic       eng_done,
  input logic       irq_done,
  input logic       busy,
  input logic       cmd_hit,
  input logic [7:0] cmd_q,
  input logic [7:0] rx_size_q,
  input logic [7:0] rx_cnt_q
);

  a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_ni)
    eng_req && !eng_done |=> eng_req && $stable(eng_op) && $stable(eng_wbyte));

  a_r11_busy_ignore: assert property (@(posedge clk) disable iff (!rst_ni)
    busy && cmd_hit |=> $stable(cmd_q));

  a_r9_done_after_steps: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(irq_done) |-> !eng_req);

  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_ni)
    busy && cmd_q[7] |-> ({1'b0, rx_cnt_q} <= {1'b0, rx_size_q} + 9'd1));

  a_r6_nack_on_read: assert property (@(posedge clk) disable iff (!rst_ni)
    eng_rx_nack |-> (eng_op == 2'd2) && cmd_q[4]);

  a_r10_stop_final: assert property (@(posedge clk) disable iff (!rst_ni)
    eng_req && eng_done && (eng_op == 2'd3) |=> !eng_req);

endmodule

bind i2c_burst_seq i2c_burst_seq_chk u_chk (
  .clk         (clk),
  .rst_ni      (rst_ni),
  .eng_req     (eng_req),
  .eng_op      (eng_op),
  .eng_wbyte   (eng_wbyte),
  .eng_rx_nack (eng_rx_nack),
  .eng_done    (eng_done),
  .irq_done    (irq_done),
  .busy        (busy),
  .cmd_hit     (cmd_hit),
  .cmd_q       (cmd_q),
  .rx_size_q   (rx_size_q),
  .rx_cnt_q    (rx_cnt_q)
);

// File: tb/i2c_burst_seq_tb.sv
`timescale 1ns/1ps
module i2c_burst_seq_tb;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_we = 1'b0;
  logic [5:0]  hst_addr = 6'd0;
  logic [31:0] hst_wdata = 32'd0;
  logic [31:0] hst_rdata;
  logic        eng_req, eng_rx_nack;
  logic [1:0]  eng_op;
  logic [7:0]  eng_wbyte;
  logic        eng_done = 1'b0;
  logic [7:0]  eng_rbyte = 8'd0;
  logic        eng_got_nack = 1'b0;
  logic        irq_done, irq_nack;

  always #(CLK_P/2) clk = ~clk;

  i2c_burst_seq u_dut (
    .clk(clk), .rst_n(rst_n), .hst_we(hst_we), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .eng_req(eng_req),
    .eng_op(eng_op), .eng_wbyte(eng_wbyte), .eng_rx_nack(eng_rx_nack),
    .eng_done(eng_done), .eng_rbyte(eng_rbyte), .eng_got_nack(eng_got_nack),
    .irq_done(irq_done), .irq_nack(irq_nack)
  );

  int n_chk = 0;
  int n_fail = 0;

  // engine model: answers each request on the third falling edge
  int         cnt = 0;
  int         ln = 0;
  logic [1:0] lop [64];
  logic [7:0] lbyte [64];
  logic       lnack [64];
  logic [7:0] rsrc [16];
  int         rsrc_i = 0;
  int         tx_seen = 0;
  int         nack_at = -1;
  logic       was_done;

  always @(negedge clk) begin
    was_done = eng_done;
    eng_done = 1'b0;
    eng_got_nack = 1'b0;
    if (eng_req && !was_done) begin
      if (cnt == 2) begin
        cnt = 0;
        eng_done = 1'b1;
        if (eng_op == 2'd1) begin
          if (tx_seen == nack_at) eng_got_nack = 1'b1;
          tx_seen++;
        end
        if (eng_op == 2'd2) begin
          eng_rbyte = rsrc[rsrc_i % 16];
          rsrc_i++;
        end
        if (ln < 64) begin
          lop[ln] = eng_op;
          lbyte[ln] = eng_wbyte;
          lnack[ln] = eng_rx_nack;
        end
        ln++;
      end else begin
        cnt++;
      end
    end else begin
      cnt = 0;
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic hw(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    hst_we = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_we = 1'b0;
  endtask

  task automatic hr(input logic [5:0] a, output logic [31:0] d);
    hst_addr = a;
    #1;
    d = hst_rdata;
  endtask

  task automatic log_clear();
    ln = 0; rsrc_i = 0; tx_seen = 0; nack_at = -1;
  endtask

  task automatic wait_done(input string rq);
    int k;
    k = 0;
    while (!irq_done && k < 1000) begin
      @(negedge clk);
      k++;
    end
    chk({rq, " completion"}, {31'd0, irq_done}, 32'd1);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    hr(6'd1, d); chk("R1 reset bufctl", d, 32'd0);
    hr(6'd3, d); chk("R9 reset flags", d, 32'd0);
    chk("R12 reset req", {31'd0, eng_req}, 32'd0);
  endtask

  task automatic t_fields();
    logic [31:0] d;
    hw(6'd1, 32'hAB12_34FF);
    hr(6'd1, d); chk("R1 field layout", d, 32'h0012_343F);
  endtask

  task automatic t_ram();
    logic [31:0] d;
    hw(6'd32, 32'h3322_11A0);
    hw(6'd33, 32'h7766_5544);
    hr(6'd32, d); chk("R2 word0", d, 32'h3322_11A0);
    hr(6'd33, d); chk("R2 word1", d, 32'h7766_5544);
  endtask

  task automatic t_tx_start();
    logic [31:0] d;
    log_clear();
    hw(6'd1, 32'h0000_0400);
    hw(6'd0, 32'h63);
    chk("R12 start held", {29'd0, eng_req, eng_op}, 32'h4);
    @(negedge clk);
    chk("R12 start still held", {29'd0, eng_req, eng_op}, 32'h4);
    chk("R9 done low in flight", {31'd0, irq_done}, 32'd0);
    wait_done("R9");
    chk("R10 step count", ln, 7);
    chk("R10 first start", {30'd0, lop[0]}, 32'd0);
    chk("R4 address byte", {24'd0, lbyte[1]}, 32'hA0);
    chk("R4 byte1", {24'd0, lbyte[2]}, 32'h11);
    chk("R4 byte2", {24'd0, lbyte[3]}, 32'h22);
    chk("R4 byte3", {24'd0, lbyte[4]}, 32'h33);
    chk("R3 byte4 last", {24'd0, lbyte[5]}, 32'h44);
    chk("R10 stop last", {30'd0, lop[6]}, 32'd3);
    chk("R8 no nack", {31'd0, irq_nack}, 32'd0);
    hw(6'd3, 32'h1);
    hr(6'd3, d); chk("R9 clear by one", d, 32'd0);
  endtask

  task automatic t_tx_single();
    log_clear();
    hw(6'd1, 32'h0000_0005);
    hw(6'd0, 32'h42);
    wait_done("R3");
    chk("R3 single byte count", ln, 1);
    chk("R3 single byte value", {24'd0, lbyte[0]}, 32'h55);
    chk("R4 write op", {30'd0, lop[0]}, 32'd1);
    hw(6'd3, 32'h3);
  endtask

  task automatic t_tx_nack();
    logic [31:0] d;
    log_clear();
    nack_at = 2;
    hw(6'd34, 32'h9988_BBAA);
    hw(6'd35, 32'hEEDD_CCCC);
    hw(6'd1, 32'h0000_0508);
    hw(6'd0, 32'hEB);
    wait_done("R8");
    chk("R8 steps", ln, 5);
    chk("R8 third write", {30'd0, lop[3]}, 32'd1);
    chk("R8 stop after nack", {30'd0, lop[4]}, 32'd3);
    chk("R8 nack flag", {31'd0, irq_nack}, 32'd1);
    hr(6'd1, d); chk("R8 tx count", {24'd0, d[15:8]}, 32'd2);
    hw(6'd3, 32'h3);
    hr(6'd3, d); chk("R9 both cleared", d, 32'd0);
  endtask

  task automatic t_rx_last();
    logic [31:0] d;
    log_clear();
    rsrc[0] = 8'hC1; rsrc[1] = 8'hC2; rsrc[2] = 8'hC3; rsrc[3] = 8'hC4;
    hw(6'd1, 32'h0003_000C);
    hw(6'd0, 32'hB8);
    wait_done("R5");
    chk("R6 steps", ln, 5);
    chk("R6 ack0", {31'd0, lnack[0]}, 32'd0);
    chk("R6 ack2", {31'd0, lnack[2]}, 32'd0);
    chk("R6 nack last", {31'd0, lnack[3]}, 32'd1);
    chk("R10 stop after read", {30'd0, lop[4]}, 32'd3);
    hr(6'd35, d); chk("R5 stored bytes", d, 32'hC4C3_C2C1);
    hr(6'd1, d); chk("R5 rx count", d, 32'h0403_000C);
    hw(6'd3, 32'h3);
  endtask

  task automatic t_rx_nolast();
    logic [31:0] d;
    log_clear();
    rsrc[0] = 8'hD1; rsrc[1] = 8'hD2;
    hw(6'd36, 32'h0);
    hw(6'd1, 32'h0001_0010);
    hw(6'd0, 32'h88);
    wait_done("R6");
    chk("R6 two reads", ln, 2);
    chk("R6 all acked", {30'd0, lnack[0], lnack[1]}, 32'd0);
    hr(6'd36, d); chk("R5 stored at offset", d, 32'h0000_D2D1);
    hr(6'd1, d); chk("R5 count two", {24'd0, d[31:24]}, 32'd2);
    hw(6'd3, 32'h3);
  endtask

  task automatic t_byte_mode();
    logic [31:0] d;
    log_clear();
    hw(6'd2, 32'h5A);
    hw(6'd0, 32'h03);
    wait_done("R7");
    chk("R7 tx steps", ln, 2);
    chk("R7 tx byte", {24'd0, lbyte[1]}, 32'h5A);
    hw(6'd3, 32'h3);
    log_clear();
    rsrc[0] = 8'hE7;
    hw(6'd0, 32'h38);
    wait_done("R7");
    chk("R7 rx steps", ln, 2);
    chk("R7 rx nack", {31'd0, lnack[0]}, 32'd1);
    hr(6'd2, d); chk("R7 rx byte", d, 32'h0000_E75A);
    hr(6'd36, d); chk("R7 buffer untouched", d, 32'h0000_D2D1);
    hr(6'd1, d); chk("R7 count untouched", {24'd0, d[31:24]}, 32'd2);
    hw(6'd3, 32'h3);
  endtask

  task automatic t_busy();
    logic [31:0] d;
    log_clear();
    hw(6'd0, 32'h20);
    hw(6'd0, 32'h03);
    wait_done("R11");
    repeat (20) @(negedge clk);
    chk("R11 only first command", ln, 1);
    chk("R11 stop op", {30'd0, lop[0]}, 32'd3);
    hr(6'd0, d); chk("R11 latched command", d, 32'h20);
    hw(6'd3, 32'h3);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL R12 watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fields();
    t_ram();
    t_tx_start();
    t_tx_single();
    t_tx_nack();
    t_rx_last();
    t_rx_nolast();
    t_byte_mode();
    t_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule